// File: doc/BRIEF.md
# Accumulator Datapath with Operand Override

This block is the execute stage of an 8-bit machine that has a single working accumulator (W) and a small array of file registers. When an instruction reads "the accumulator" as an operand, it does not read W. It reads a separate operand register (S). After every ordinary instruction, S is reloaded with the new value of W, so S normally tracks W.

Two override instructions break that tracking for exactly one instruction. One loads S from a file register and the other loads S from an immediate value. Neither touches W. The instruction that follows therefore combines two file registers, or a file register and a constant, and the accumulator keeps its value.

Interrupts are taken only at an instruction boundary that does not separate an override from its follower. On entry the block saves W and S into backup registers. A return strobe restores both. A decoder drives one decoded instruction per clock. A read port on the file array lets the surrounding logic observe the registers.

Top module: `acc_srcov_core`

## Requirements
- R1: Every valid instruction other than the two overrides, including undefined opcodes, leaves S equal to the W value it produced.
- R2: Every ALU operation uses S as its accumulator-side operand. Add yields F+S and subtract yields F−S, where F is the addressed file register.
- R3: The file override (opcode 8) copies the addressed file register into S and leaves W and both flags unchanged.
- R4: The immediate override (opcode 9) copies the immediate into S and leaves W and both flags unchanged.
- R5: A file override of register a followed by an add of register b with file destination leaves the old a plus the old b (mod 256) in register b, and leaves W unchanged.
- R6: For add, subtract, and, or, xor and move-file, destination bit 1 writes the result to the addressed file register and destination bit 0 writes it to W. Move-W-to-file (opcode 7) always stores S into the file register.
- R7: Add, subtract, and, or, xor and move-file set Z when the 8-bit result is zero. Add sets C to the carry out. Subtract sets C to 1 exactly when F ≥ S, meaning no borrow. All other opcodes leave both flags unchanged.
- R8: No interrupt is accepted in a cycle that executes an override, nor in idle cycles after it. Acceptance becomes possible once the next valid instruction has completed.
- R9: An accept pulse (irq_ack) fires when irq_req is high, interrupts are enabled and no deferral applies. On that edge it saves the post-instruction W and S and disables interrupts. A return strobe restores W and S, re-enables interrupts and ignores any instruction presented in the same cycle.
- R10: After reset, W, S, the flags, the backups and all file registers are zero, and interrupts are enabled.
- R11: A cycle with instr_valid low and no return strobe changes no state.
- R12: Opcodes are: 0 nop, 1 add, 2 subtract, 3 and, 4 or, 5 xor, 6 move-file, 7 move-W-to-file, 8 file override, 9 immediate override, 10 load W with the immediate. Codes 11 to 15 behave as nop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Decoded instruction present this cycle |
| instr_op | input | 4 | Opcode, encoding per R12 |
| instr_addr | input | ADDR_W (4) | File register address |
| instr_imm | input | DATA_W (8) | Immediate operand |
| instr_to_file | input | 1 | Destination select: 1 file, 0 W |
| irq_req | input | 1 | Interrupt request level |
| reti | input | 1 | Return-from-interrupt strobe |
| w_out | output | DATA_W (8) | Accumulator W |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| irq_ack | output | 1 | Interrupt accepted at this edge |
| dbg_addr | input | ADDR_W (4) | File read-port address |
| dbg_data | output | DATA_W (8) | File read-port data |

## Verification
The embedded assertions check four things on every cycle:
- S mirrors W after each ordinary instruction.
- Both overrides keep W and the flags still.
- No accept pulse appears during an override.
- Idle cycles change nothing, and an accept is never followed directly by another.

Only the bench's scenarios can show the behaviours that depend on data:
- the register-to-register sum after a file override;
- the carry and borrow corner values;
- deferral that lasts through idle gaps between an override and its follower;
- whether the saved W and S return intact after an interrupt routine has overwritten both.

A behavioural model compares W, the flags, the accept pulse and all sixteen file registers after every clock.

// File: rtl/acc_pkg.sv
package acc_pkg;
   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_ADD   = 4'd1,
      OP_SUB   = 4'd2,
      OP_AND   = 4'd3,
      OP_OR    = 4'd4,
      OP_XOR   = 4'd5,
      OP_MOVF  = 4'd6,
      OP_MOVWF = 4'd7,
      OP_LDSF  = 4'd8,
      OP_LDSI  = 4'd9,
      OP_MOVLW = 4'd10
   } op_t;

   function automatic logic is_override(input logic [3:0] op);
      return (op == OP_LDSF) || (op == OP_LDSI);
   endfunction
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int DATA_W = 8,
   parameter bit SUB_CARRY_NOBORROW = 1'b1
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] opnd_f,
   input  logic [DATA_W-1:0] opnd_s,
   output logic [DATA_W-1:0] result,
   output logic              res_valid,
   output logic              z_new,
   output logic              c_new,
   output logic              upd_c
);
   import acc_pkg::*;

   logic [DATA_W:0] sum_w;
   logic [DATA_W:0] dif_w;
   logic            sub_carry;

   assign sum_w = {1'b0, opnd_f} + {1'b0, opnd_s};
   assign dif_w = {1'b0, opnd_f} - {1'b0, opnd_s};

   generate
      if (SUB_CARRY_NOBORROW) begin : g_noborrow
         assign sub_carry = ~dif_w[DATA_W];
      end else begin : g_borrow
         assign sub_carry = dif_w[DATA_W];
      end
   endgenerate

   always_comb begin
      result    = '0;
      res_valid = 1'b1;
      c_new     = 1'b0;
      upd_c     = 1'b0;
      unique case (op)
         OP_ADD:  begin result = sum_w[DATA_W-1:0]; c_new = sum_w[DATA_W]; upd_c = 1'b1; end
         OP_SUB:  begin result = dif_w[DATA_W-1:0]; c_new = sub_carry;     upd_c = 1'b1; end
         OP_AND:  result = opnd_f & opnd_s;
         OP_OR:   result = opnd_f | opnd_s;
         OP_XOR:  result = opnd_f ^ opnd_s;
         OP_MOVF: result = opnd_f;
         default: res_valid = 1'b0;
      endcase
   end

   assign z_new = (result == '0);
endmodule

// File: rtl/acc_file_regs.sv
module acc_file_regs #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] dbg_addr,
   output logic [DATA_W-1:0] dbg_data
);
   logic [DATA_W-1:0] cell_q [DEPTH];

   generate
      if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("acc_file_regs: DEPTH must be a power of two >= 2");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cell_q[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
               cell_q[i] <= wr_data;
         end
      end
   endgenerate

   assign rd_data  = cell_q[rd_addr];
   assign dbg_data = cell_q[dbg_addr];
endmodule

// File: rtl/acc_irq_ctrl.sv
module acc_irq_ctrl #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec,
   input  logic              exec_ovr,
   input  logic              irq_req,
   input  logic              reti,
   input  logic [DATA_W-1:0] w_next,
   input  logic [DATA_W-1:0] s_next,
   output logic              irq_ack,
   output logic [DATA_W-1:0] bak_w,
   output logic [DATA_W-1:0] bak_s
);
   logic lock_q, lock_nx, ie_q;

   assign lock_nx = exec ? exec_ovr : lock_q;
   assign irq_ack = irq_req & ie_q & ~reti & ~lock_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         ie_q   <= 1'b1;
         bak_w  <= '0;
         bak_s  <= '0;
      end else begin
         lock_q <= lock_nx;
         if (reti)
            ie_q <= 1'b1;
         else if (irq_ack)
            ie_q <= 1'b0;
         if (irq_ack) begin
            bak_w <= w_next;
            bak_s <= s_next;
         end
      end
   end

   assert_ack_drops_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);

   assert_override_defers_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && exec_ovr) |-> !irq_ack);
endmodule

// File: rtl/acc_srcov_core.sv
module acc_srcov_core #(
   parameter int DATA_W     = 8,
   parameter int FILE_DEPTH = 16,
   parameter bit SUB_CARRY_NOBORROW = 1'b1,
   localparam int ADDR_W = $clog2(FILE_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [3:0]        instr_op,
   input  logic [ADDR_W-1:0] instr_addr,
   input  logic [DATA_W-1:0] instr_imm,
   input  logic              instr_to_file,
   input  logic              irq_req,
   input  logic              reti,
   output logic [DATA_W-1:0] w_out,
   output logic              flag_z,
   output logic              flag_c,
   output logic              irq_ack,
   input  logic [ADDR_W-1:0] dbg_addr,
   output logic [DATA_W-1:0] dbg_data
);
   import acc_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("acc_srcov_core: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] w_q, s_q, w_nx, s_nx;
   logic [DATA_W-1:0] f_rd, alu_res, f_wdata, bak_w, bak_s;
   logic              z_q, c_q, alu_ok, alu_z, alu_c, alu_updc;
   logic              exec, ovr, f_we;
   op_t               op;

   assign op   = op_t'(instr_op);
   assign exec = instr_valid & ~reti;
   assign ovr  = is_override(instr_op);

   acc_alu #(.DATA_W(DATA_W), .SUB_CARRY_NOBORROW(SUB_CARRY_NOBORROW)) u_alu (
      .op(instr_op), .opnd_f(f_rd), .opnd_s(s_q), .result(alu_res),
      .res_valid(alu_ok), .z_new(alu_z), .c_new(alu_c), .upd_c(alu_updc));

   assign f_we    = exec & ((alu_ok & instr_to_file) | (op == OP_MOVWF));
   assign f_wdata = (op == OP_MOVWF) ? s_q : alu_res;

   acc_file_regs #(.DATA_W(DATA_W), .DEPTH(FILE_DEPTH)) u_file (
      .clk(clk), .rst_n(rst_n), .wr_en(f_we), .wr_addr(instr_addr),
      .wr_data(f_wdata), .rd_addr(instr_addr), .rd_data(f_rd),
      .dbg_addr(dbg_addr), .dbg_data(dbg_data));

   always_comb begin
      w_nx = w_q;
      s_nx = s_q;
      if (reti) begin
         w_nx = bak_w;
         s_nx = bak_s;
      end else if (exec) begin
         if (alu_ok && !instr_to_file) w_nx = alu_res;
         else if (op == OP_MOVLW)      w_nx = instr_imm;
         if (op == OP_LDSF)            s_nx = f_rd;
         else if (op == OP_LDSI)       s_nx = instr_imm;
         else                          s_nx = w_nx;
      end
   end

   acc_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .exec(exec), .exec_ovr(ovr),
      .irq_req(irq_req), .reti(reti), .w_next(w_nx), .s_next(s_nx),
      .irq_ack(irq_ack), .bak_w(bak_w), .bak_s(bak_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q <= '0;
         s_q <= '0;
         z_q <= 1'b0;
         c_q <= 1'b0;
      end else begin
         w_q <= w_nx;
         s_q <= s_nx;
         if (exec && alu_ok)   z_q <= alu_z;
         if (exec && alu_updc) c_q <= alu_c;
      end
   end

   assign w_out  = w_q;
   assign flag_z = z_q;
   assign flag_c = c_q;

   assert_src_mirrors_w_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && !ovr) |=> (s_q == w_q));

   assert_override_keeps_w_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && ovr) |=> ($stable(w_q) && $stable(z_q) && $stable(c_q)));

   assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_valid && !reti) |=> ($stable(w_q) && $stable(s_q) && $stable(z_q) && $stable(c_q)));
endmodule

// File: tb/sim_acc_srcov_core.sv
`timescale 1ns/1ps
module sim_acc_srcov_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       instr_valid = 1'b0;
   logic [3:0] instr_op = '0;
   logic [3:0] instr_addr = '0;
   logic [7:0] instr_imm = '0;
   logic       instr_to_file = 1'b0;
   logic       irq_req = 1'b0;
   logic       reti = 1'b0;
   logic [7:0] w_out;
   logic       flag_z, flag_c, irq_ack;
   logic [3:0] dbg_addr = '0;
   logic [7:0] dbg_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int mw, ms, mz, mc, mie, mlock, mbw, mbs;
   int mf[16];

   always #2 clk = ~clk;

   acc_srcov_core u0 (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
      .instr_addr(instr_addr), .instr_imm(instr_imm), .instr_to_file(instr_to_file),
      .irq_req(irq_req), .reti(reti), .w_out(w_out), .flag_z(flag_z),
      .flag_c(flag_c), .irq_ack(irq_ack), .dbg_addr(dbg_addr), .dbg_data(dbg_data));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_ack();
      int nl;
      nl = (instr_valid && !reti) ? int'(instr_op == 8 || instr_op == 9) : mlock;
      return int'(irq_req && mie != 0 && !reti && nl == 0);
   endfunction

   task automatic model_tick();
      int f, r, ack, nl, a;
      bit ovr;
      ack = exp_ack();
      a   = instr_addr;
      f   = mf[a];
      ovr = (instr_op == 8 || instr_op == 9);
      nl  = (instr_valid && !reti) ? int'(ovr) : mlock;
      if (reti) begin
         mw = mbw; ms = mbs; mie = 1;
      end else if (instr_valid) begin
         r = -1;
         case (instr_op)
            1: begin r = (f + ms) % 256; mc = int'(f + ms > 255); end
            2: begin r = (f - ms + 256) % 256; mc = int'(f >= ms); end
            3: r = f & ms;
            4: r = f | ms;
            5: r = f ^ ms;
            6: r = f;
            7: mf[a] = ms;
            8: ms = f;
            9: ms = instr_imm;
            10: mw = instr_imm;
            default: ;
         endcase
         if (r >= 0) begin
            mz = int'(r == 0);
            if (instr_to_file) mf[a] = r; else mw = r;
         end
         if (!ovr) ms = mw;
      end
      if (ack != 0) begin
         mbw = mw; mbs = ms; mie = 0;
      end
      mlock = nl;
   endtask

   task automatic compare_all(input string tag);
      chk({tag, " R6 w"}, int'(w_out), mw);
      chk({tag, " R7 z"}, int'(flag_z), mz);
      chk({tag, " R7 c"}, int'(flag_c), mc);
      for (int i = 0; i < 16; i++) begin
         dbg_addr = 4'(i);
         #0.05;
         chk({tag, " R6 file"}, int'(dbg_data), mf[i]);
      end
   endtask

   task automatic step(input bit v, input int op, input int a, input int imm,
                       input bit tf, input bit irq, input bit rt, input string tag);
      instr_valid = v; instr_op = 4'(op); instr_addr = 4'(a); instr_imm = 8'(imm);
      instr_to_file = tf; irq_req = irq; reti = rt;
      #0.3;
      chk({tag, " R8 R9 ack"}, int'(irq_ack), exp_ack());
      @(posedge clk);
      model_tick();
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic idle(input bit irq, input string tag);
      step(1'b0, 0, 0, 0, 1'b0, irq, 1'b0, tag);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      mw = 0; ms = 0; mz = 0; mc = 0; mie = 1; mlock = 0; mbw = 0; mbs = 0;
      for (int i = 0; i < 16; i++) mf[i] = 0;
      repeat (3) @(negedge clk);
      compare_all("reset R10");
      rst_n = 1'b1;
      @(negedge clk);
      // R10: interrupts enabled out of reset, S and backups zero
      step(1'b1, 1, 3, 0, 1'b0, 1'b0, 1'b0, "R10 add zero");
      // R12 encodings, R6 destinations
      step(1'b1, 10, 0, 5, 1'b0, 1'b0, 1'b0, "R12 movlw");
      step(1'b1, 7, 1, 0, 1'b0, 1'b0, 1'b0, "R6 movwf f1");
      step(1'b1, 10, 0, 7, 1'b0, 1'b0, 1'b0, "R12 movlw 7");
      step(1'b1, 7, 2, 0, 1'b0, 1'b0, 1'b0, "R6 movwf f2");
      // R5: file override then add to file
      step(1'b1, 8, 1, 0, 1'b0, 1'b0, 1'b0, "R3 ldsf f1");
      step(1'b1, 1, 2, 0, 1'b1, 1'b0, 1'b0, "R5 add f2");
      chk("R5 sum", mf[2], 12);
      chk("R5 w kept", int'(w_out), 7);
      // R4 / R2: immediate override feeds add with W destination
      step(1'b1, 9, 0, 250, 1'b0, 1'b0, 1'b0, "R4 ldsi");
      step(1'b1, 1, 2, 0, 1'b0, 1'b0, 1'b0, "R2 add carry");
      chk("R7 carry set", int'(flag_c), 1);
      // R7 subtract borrow and no-borrow; R1 S mirrors W again
      step(1'b1, 2, 1, 0, 1'b0, 1'b0, 1'b0, "R7 sub borrow");
      step(1'b1, 9, 0, 5, 1'b0, 1'b0, 1'b0, "R4 ldsi 5");
      step(1'b1, 2, 1, 0, 1'b1, 1'b0, 1'b0, "R7 sub equal");
      chk("R7 zero", int'(flag_z), 1);
      step(1'b1, 5, 2, 0, 1'b0, 1'b0, 1'b0, "R1 xor uses mirror");
      step(1'b1, 3, 2, 0, 1'b1, 1'b0, 1'b0, "R7 and");
      step(1'b1, 13, 0, 0, 1'b0, 1'b0, 1'b0, "R12 undefined");
      // R11: invalid strobe with junk fields
      step(1'b0, 10, 4, 99, 1'b1, 1'b0, 1'b0, "R11 invalid");
      // R8: deferral across override, idle gaps, then follower
      step(1'b1, 9, 0, 33, 1'b0, 1'b1, 1'b0, "R8 ldsi irq");
      idle(1'b1, "R8 gap1");
      idle(1'b1, "R8 gap2");
      step(1'b1, 1, 2, 0, 1'b0, 1'b1, 1'b0, "R8 follower accept");
      // R9: ISR clobbers W and S, then return restores
      step(1'b1, 10, 0, 77, 1'b0, 1'b1, 1'b0, "R9 isr movlw");
      step(1'b1, 9, 0, 88, 1'b0, 1'b1, 1'b0, "R9 isr ldsi");
      step(1'b1, 10, 0, 11, 1'b0, 1'b0, 1'b1, "R9 reti ignores instr");
      step(1'b1, 1, 5, 0, 1'b1, 1'b0, 1'b0, "R9 S restored");
      // Mixed stimulus
      for (int n = 0; n < 1500; n++) begin
         int r;
         r = int'($urandom_range(0, 99));
         step(r < 85, int'($urandom_range(0, 12)), int'($urandom_range(0, 15)),
              int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
              r < 30, (r > 95), "mixed R1 R2 R7");
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule